// File: doc/BRIEF.md
# Status Channel Synchronization Monitor

This block watches a two-bit flow-control status channel and decides whether the far end is sending well-formed calendar passes. Each pass begins with a framing code `11`. In two-calendar mode a selection word comes next. Then come a configured number of status codes and a two-bit parity word. The block checks the parity word of every pass.

Runs of passing and failing checks move a two-state machine between out-of-synch and in-synch. The lengths of those runs are configuration inputs. A long unbroken run of `11` codes forces the machine out of synch, and so do a training indication, a disabled port and reset. The block reports the current state and the active calendar. It raises a latched interrupt whenever the state changes.

Top module: `ssm_status_sync`

## Requirements
- R1: After synchronous reset `in_sync`, `irq` and `cal_sel` are all 0, and both run counters are cleared.
- R2: While out of synch, `cfg_good_len` consecutive passing passes raise `in_sync`. The rise happens at the clock edge that samples the last parity word. A length of 0 acts as 1.
- R3: While in synch, `cfg_bad_len` consecutive failing passes clear `in_sync` at the edge that samples the last parity word. A length of 0 acts as 1.
- R4: A failing pass clears the good-run count, and a passing pass clears the bad-run count. Any state change clears both counts.
- R5: Twelve consecutive valid `11` codes clear `in_sync` at the edge that samples the twelfth. This takes priority over any pass result on that edge. Cycles with `stat_vld` low neither extend nor break a run.
- R6: `train_det` high or `port_en` low clears `in_sync` and the run counters on that edge. They also return the pass parser to framing hunt.
- R7: Pass format: framing `11`, then an optional selection word, then `cfg_cal_len` status codes (1 to 2^CAL_W-1), then the parity word. The parity word passes when bit 1 is the inverted XOR of bit 1 of all status codes in the pass, and bit 0 is the inverted XOR of bit 0 (odd parity). The selection word is not covered by the parity.
- R8: With `two_cal_en` high, a selection word `01` sets `cal_sel` to 0 and `10` sets it to 1. With `two_cal_en` low, no selection word is expected and `cal_sel` holds its value.
- R9: A selection word of `00` or `11` leaves `cal_sel` unchanged, and that pass counts as failing whatever its parity.
- R10: Every change of `in_sync` sets a sticky flag, and `irq_ack` clears it; a change in the same cycle as `irq_ack` wins. `irq` is the registered AND of the flag and `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Port enable; low forces out of synch |
| train_det | input | 1 | Training pattern seen; forces out of synch |
| two_cal_en | input | 1 | Expect a calendar selection word after framing |
| cfg_cal_len | input | CAL_W | Status codes per calendar pass |
| cfg_good_len | input | RUN_W | Passing passes needed to enter synch |
| cfg_bad_len | input | RUN_W | Failing passes needed to leave synch |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Clears the latched change flag |
| stat_vld | input | 1 | `stat_code` holds a valid code this cycle |
| stat_code | input | 2 | Received status code |
| in_sync | output | 1 | Synchronization state, 1 = in synch |
| cal_sel | output | 1 | Active calendar |
| irq | output | 1 | State-change interrupt |

## Verification
The bench builds the block with CAL_W = 3 and RUN_W = 3, so pass lengths of 1 to 7 codes and run lengths of 1 to 7 can all be reached without a rebuild. It sweeps every pair of good and bad run lengths from 1 to 4. It also covers every pass length against three data patterns and all four corruption masks of the parity word. Because the run lengths, the pass length and the calendar mode are inputs, each case takes only a port pulse to set up, and the twelve-code framing run fits into two short passes.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [1:0] {
    P_HUNT,
    P_SEL,
    P_DATA,
    P_DIP
  } parse_st_t;

  localparam logic [1:0] CODE_FRAME = 2'b11;
  localparam logic [1:0] SEL_CAL0   = 2'b01;
  localparam logic [1:0] SEL_CAL1   = 2'b10;
endpackage

// File: rtl/ssm_pass_parser.sv
module ssm_pass_parser
  import ssm_pkg::*;
#(
  parameter int CAL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             vld,
  input  logic [1:0]       code,
  input  logic             two_cal,
  input  logic [CAL_W-1:0] cal_len,
  output logic             pass_done,
  output logic             pass_good,
  output logic             cal_sel
);
  parse_st_t        st;
  logic [CAL_W-1:0] cnt;
  logic [1:0]       par;
  logic             sel_bad;
  logic [CAL_W-1:0] last_idx;

  assign last_idx  = cal_len - CAL_W'(1);
  assign pass_done = vld && (st == P_DIP) && !flush;
  assign pass_good = (code == ~par) && !sel_bad;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      st      <= P_HUNT;
      cnt     <= '0;
      par     <= '0;
      sel_bad <= 1'b0;
    end else if (vld) begin
      case (st)
        P_HUNT: if (code == CODE_FRAME) begin
          st      <= two_cal ? P_SEL : P_DATA;
          cnt     <= '0;
          par     <= '0;
          sel_bad <= 1'b0;
        end
        P_SEL: begin
          sel_bad <= (code != SEL_CAL0) && (code != SEL_CAL1);
          st      <= P_DATA;
        end
        P_DATA: begin
          par <= par ^ code;
          if (cnt == last_idx) st <= P_DIP;
          else cnt <= cnt + CAL_W'(1);
        end
        default: st <= P_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cal_sel <= 1'b0;
    else if (vld && !flush && st == P_SEL) begin
      if (code == SEL_CAL0) cal_sel <= 1'b0;
      else if (code == SEL_CAL1) cal_sel <= 1'b1;
    end
  end

  // R8: the active calendar moves only after a selection word was sampled
  assert_sel_source_R8: assert property (@(posedge clk) disable iff (rst)
    (cal_sel != $past(cal_sel)) |-> $past(st == P_SEL && vld));

  // R9: an invalid selection word leaves the calendar untouched
  assert_bad_sel_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (vld && st == P_SEL && (code == 2'b00 || code == 2'b11)) |=> $stable(cal_sel));
endmodule

// File: rtl/ssm_ones_run.sv
module ssm_ones_run
  import ssm_pkg::*;
#(
  parameter int RUN_LEN = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vld,
  input  logic [1:0] code,
  output logic       hit
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] TOP = CW'(RUN_LEN - 1);

  logic [CW-1:0] run;

  assign hit = vld && (code == CODE_FRAME) && (run == TOP);

  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (vld) begin
      if (code != CODE_FRAME) run <= '0;
      else if (run != TOP) run <= run + CW'(1);
    end
  end
endmodule

// File: rtl/ssm_sync_fsm.sv
module ssm_sync_fsm #(
  parameter int RUN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             force_out,
  input  logic             pass_done,
  input  logic             pass_good,
  input  logic [RUN_W-1:0] good_len,
  input  logic [RUN_W-1:0] bad_len,
  input  logic             irq_en,
  input  logic             irq_ack,
  output logic             in_sync,
  output logic             irq
);
  localparam int EW = RUN_W + 1;

  logic [RUN_W-1:0] good_cnt, bad_cnt;
  logic             sync_nx, flag, flag_nx;
  logic [EW-1:0]    good_inc, bad_inc;

  assign good_inc = EW'(good_cnt) + EW'(1);
  assign bad_inc  = EW'(bad_cnt) + EW'(1);

  always_comb begin
    sync_nx = in_sync;
    if (force_out) sync_nx = 1'b0;
    else if (pass_done) begin
      if (pass_good && !in_sync && good_inc >= EW'(good_len)) sync_nx = 1'b1;
      if (!pass_good && in_sync && bad_inc >= EW'(bad_len)) sync_nx = 1'b0;
    end
  end

  assign flag_nx = (sync_nx != in_sync) || (flag && !irq_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_sync  <= 1'b0;
      good_cnt <= '0;
      bad_cnt  <= '0;
      flag     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      in_sync <= sync_nx;
      flag    <= flag_nx;
      irq     <= flag_nx && irq_en;
      if (force_out || sync_nx != in_sync) begin
        good_cnt <= '0;
        bad_cnt  <= '0;
      end else if (pass_done) begin
        if (pass_good) begin
          bad_cnt <= '0;
          if (!in_sync) good_cnt <= good_inc[RUN_W-1:0];
        end else begin
          good_cnt <= '0;
          if (in_sync) bad_cnt <= bad_inc[RUN_W-1:0];
        end
      end
    end
  end

  // R5/R6: any forcing condition leaves the machine out of synch
  assert_force_drop_R6: assert property (@(posedge clk) disable iff (rst)
    force_out |=> !in_sync);

  // R2: entering synch needs a passing pass on the previous edge
  assert_rise_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(in_sync) |-> $past(pass_done && pass_good));

  // R3: leaving synch needs a failing pass or a forcing condition
  assert_fall_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(in_sync) |-> $past(force_out || (pass_done && !pass_good)));

  // R2/R3: the state holds while there is no pass result and no force
  assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!force_out && !pass_done) |=> $stable(in_sync));

  // R10: an enabled state change shows up on the interrupt
  assert_change_irq_R10: assert property (@(posedge clk) disable iff (rst)
    ((in_sync != $past(in_sync)) && $past(irq_en)) |-> irq);
endmodule

// File: rtl/ssm_status_sync.sv
module ssm_status_sync #(
  parameter int CAL_W   = 3,
  parameter int RUN_W   = 3,
  parameter int ONES_RUN = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             port_en,
  input  logic             train_det,
  input  logic             two_cal_en,
  input  logic [CAL_W-1:0] cfg_cal_len,
  input  logic [RUN_W-1:0] cfg_good_len,
  input  logic [RUN_W-1:0] cfg_bad_len,
  input  logic             irq_en,
  input  logic             irq_ack,
  input  logic             stat_vld,
  input  logic [1:0]       stat_code,
  output logic             in_sync,
  output logic             cal_sel,
  output logic             irq
);
  logic flush, ones_hit, pass_done, pass_good;

  assign flush = train_det || !port_en;

  ssm_pass_parser #(.CAL_W(CAL_W)) u_parse (
    .clk(clk), .rst(rst), .flush(flush), .vld(stat_vld), .code(stat_code),
    .two_cal(two_cal_en), .cal_len(cfg_cal_len),
    .pass_done(pass_done), .pass_good(pass_good), .cal_sel(cal_sel)
  );

  ssm_ones_run #(.RUN_LEN(ONES_RUN)) u_ones (
    .clk(clk), .rst(rst), .vld(stat_vld), .code(stat_code), .hit(ones_hit)
  );

  ssm_sync_fsm #(.RUN_W(RUN_W)) u_fsm (
    .clk(clk), .rst(rst), .force_out(flush || ones_hit),
    .pass_done(pass_done), .pass_good(pass_good),
    .good_len(cfg_good_len), .bad_len(cfg_bad_len),
    .irq_en(irq_en), .irq_ack(irq_ack), .in_sync(in_sync), .irq(irq)
  );
endmodule

// File: tb/tb_ssm_status_sync.sv
module tb_ssm_status_sync;
  localparam int CAL_W = 3;
  localparam int RUN_W = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, port_en = 1'b1, train_det = 1'b0, two_cal_en = 1'b0;
  logic [CAL_W-1:0] cfg_cal_len = 3'd4;
  logic [RUN_W-1:0] cfg_good_len = 3'd1, cfg_bad_len = 3'd1;
  logic irq_en = 1'b0, irq_ack = 1'b0, stat_vld = 1'b0;
  logic [1:0] stat_code = 2'b00;
  logic in_sync, cal_sel, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  ssm_status_sync #(.CAL_W(CAL_W), .RUN_W(RUN_W)) dut (
    .clk(clk), .rst(rst), .port_en(port_en), .train_det(train_det),
    .two_cal_en(two_cal_en), .cfg_cal_len(cfg_cal_len),
    .cfg_good_len(cfg_good_len), .cfg_bad_len(cfg_bad_len),
    .irq_en(irq_en), .irq_ack(irq_ack), .stat_vld(stat_vld),
    .stat_code(stat_code), .in_sync(in_sync), .cal_sel(cal_sel), .irq(irq)
  );

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic send(logic [1:0] c);
    @(negedge clk);
    stat_vld  = 1'b1;
    stat_code = c;
    @(posedge clk);
    #1;
    stat_vld = 1'b0;
  endtask

  // frame, optional selection word, len data codes, parity word (flip corrupts it)
  task automatic pass(int len, int seed, logic [1:0] flip, logic [1:0] sel);
    logic [1:0] par = 2'b00;
    send(2'b11);
    if (two_cal_en) send(sel);
    for (int i = 0; i < len; i++) begin
      logic [1:0] d = 2'((seed + i) % 3);
      par ^= d;
      send(d);
    end
    send(~par ^ flip);
  endtask

  task automatic port_off();
    @(negedge clk);
    port_en = 1'b0;
    @(posedge clk);
    #1;
    port_en = 1'b1;
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(posedge clk);
    #1;
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 in_sync", int'(in_sync), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 cal_sel", int'(cal_sel), 0);
    @(negedge clk);
    rst = 1'b0;

    // R2/R3: sweep of run lengths
    for (int g = 1; g <= 4; g++) begin
      for (int b = 1; b <= 4; b++) begin
        cfg_good_len = RUN_W'(g);
        cfg_bad_len  = RUN_W'(b);
        port_off();
        for (int k = 1; k <= g; k++) begin
          pass(4, k, 2'b00, 2'b01);
          chk("R2 good run", int'(in_sync), (k >= g) ? 1 : 0);
        end
        for (int k = 1; k <= b; k++) begin
          pass(4, k, 2'b01, 2'b01);
          chk("R3 bad run", int'(in_sync), (k < b) ? 1 : 0);
        end
      end
    end

    // R7: parity over every pass length, data pattern and corruption mask
    cfg_good_len = 3'd1;
    cfg_bad_len  = 3'd1;
    for (int len = 1; len <= 7; len++) begin
      cfg_cal_len = CAL_W'(len);
      for (int s = 0; s < 3; s++) begin
        for (int f = 0; f < 4; f++) begin
          port_off();
          pass(len, s, 2'(f), 2'b01);
          chk("R7 parity", int'(in_sync), (f == 0) ? 1 : 0);
        end
      end
    end
    cfg_cal_len = 3'd4;

    // R4: opposite events clear the run counts
    cfg_good_len = 3'd3;
    cfg_bad_len  = 3'd3;
    port_off();
    pass(4, 0, 2'b00, 2'b01);
    pass(4, 1, 2'b00, 2'b01);
    pass(4, 2, 2'b10, 2'b01);
    pass(4, 0, 2'b00, 2'b01);
    pass(4, 1, 2'b00, 2'b01);
    chk("R4 good count cleared", int'(in_sync), 0);
    pass(4, 2, 2'b00, 2'b01);
    chk("R4 good run after clear", int'(in_sync), 1);
    pass(4, 0, 2'b11, 2'b01);
    pass(4, 1, 2'b11, 2'b01);
    pass(4, 2, 2'b00, 2'b01);
    pass(4, 0, 2'b11, 2'b01);
    pass(4, 1, 2'b11, 2'b01);
    chk("R4 bad count cleared", int'(in_sync), 1);
    pass(4, 2, 2'b11, 2'b01);
    chk("R4 bad run after clear", int'(in_sync), 0);

    // R5: twelve consecutive framing codes
    cfg_good_len = 3'd1;
    cfg_bad_len  = 3'd7;
    port_off();
    pass(4, 0, 2'b00, 2'b01);
    chk("R5 setup", int'(in_sync), 1);
    for (int k = 1; k <= 11; k++) send(2'b11);
    chk("R5 eleven ones", int'(in_sync), 1);
    send(2'b11);
    chk("R5 twelfth one", int'(in_sync), 0);

    // R6: training, port disable, parser restart
    cfg_bad_len = 3'd1;
    port_off();
    pass(4, 1, 2'b00, 2'b01);
    @(negedge clk);
    train_det = 1'b1;
    @(posedge clk);
    #1;
    train_det = 1'b0;
    chk("R6 training drop", int'(in_sync), 0);
    pass(4, 1, 2'b00, 2'b01);
    chk("R6 resync after training", int'(in_sync), 1);
    port_off();
    chk("R6 port disable drop", int'(in_sync), 0);
    send(2'b11);
    send(2'b01);
    send(2'b10);
    port_off();
    pass(4, 2, 2'b00, 2'b01);
    chk("R6 parser restarted", int'(in_sync), 1);

    // R8/R9: calendar selection word
    two_cal_en = 1'b1;
    port_off();
    pass(4, 0, 2'b00, 2'b10);
    chk("R8 sel 10", int'(cal_sel), 1);
    chk("R8 sel pass good", int'(in_sync), 1);
    pass(4, 1, 2'b00, 2'b01);
    chk("R8 sel 01", int'(cal_sel), 0);
    pass(4, 1, 2'b00, 2'b10);
    pass(4, 2, 2'b00, 2'b11);
    chk("R9 sel 11 keeps cal", int'(cal_sel), 1);
    chk("R9 sel 11 is error", int'(in_sync), 0);
    pass(4, 2, 2'b00, 2'b10);
    pass(4, 0, 2'b00, 2'b00);
    chk("R9 sel 00 keeps cal", int'(cal_sel), 1);
    chk("R9 sel 00 is error", int'(in_sync), 0);
    two_cal_en = 1'b0;
    pass(4, 0, 2'b00, 2'b01);
    chk("R8 single mode no sel", int'(cal_sel), 1);
    chk("R8 single mode pass", int'(in_sync), 1);

    // R10: interrupt latch, ack and enable
    port_off();
    ack();
    irq_en = 1'b1;
    @(posedge clk);
    #1;
    chk("R10 idle irq", int'(irq), 0);
    pass(4, 0, 2'b00, 2'b01);
    chk("R10 irq on rise", int'(irq), 1);
    ack();
    chk("R10 ack clears", int'(irq), 0);
    irq_en = 1'b0;
    pass(4, 0, 2'b01, 2'b01);
    chk("R10 masked", int'(irq), 0);
    chk("R10 fall seen", int'(in_sync), 0);
    @(negedge clk);
    irq_en = 1'b1;
    @(posedge clk);
    #1;
    chk("R10 sticky flag", int'(irq), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule